// File: doc/BRIEF.md
# Half-Precision Fraction Remainder Vector Unit

This block takes a vector of half-precision lanes and, for each lane, rounds the value to a chosen number of binary digits below the binary point. It returns what is left over: the input minus that rounded value. The result is rounded back to half precision in the same mode. An 8-bit control immediate sets the number of kept fraction digits and the rounding mode. The rounding mode can come from the immediate or from an external default-mode field. The immediate can also silence the inexact report.

Each lane has a write-enable bit. A disabled lane either keeps the previous destination value (merge) or is written with +0 (zeroing). A broadcast option feeds source lane 0 to every lane. Results are registered: a request on `inValid` gives `outValid` with the result one clock later. A sticky inexact flag records whether any enabled lane of any accepted request lost bits in its rounding. The lane count is a parameter (8, 16 or 32).

Top module: `fprd_reduce_unit`

## Requirements
- R1: For a finite lane input x, the lane result is x − R(x). R(x) is x rounded to a multiple of 2^−M, where M is `ctrlImm[7:4]` (0 to 15). M = 0 rounds to an integer.
- R2: When `ctrlImm[2]` = 0, the rounding mode is `ctrlImm[1:0]`: 0 = nearest with ties to even, 1 = toward −∞, 2 = toward +∞, 3 = toward zero.
- R3: When `ctrlImm[2]` = 1, the rounding mode is `dfltMode`, using the same encoding, and `ctrlImm[1:0]` is ignored.
- R4: When R(x) equals x (this includes zeros and all values with no bits below 2^−M), the lane result is a zero. The zero is −0 (0x8000) under mode 1 and +0 (0x0000) otherwise.
- R5: A NaN input gives the same NaN with fraction bit 9 set. An infinity gives a zero of the same sign. Neither case counts as inexact.
- R6: A lane whose `wrMask` bit is 0 outputs its `oldDst` lane when `zeroMode` = 0 and 0x0000 when `zeroMode` = 1.
- R7: When `bcastEn` = 1, every lane uses bits [15:0] of `srcVec` as its input.
- R8: `inexFlag` is sticky and cleared only by reset. An accepted request sets it if any lane with its `wrMask` bit set has R(x) ≠ x and `ctrlImm[3]` = 0. When `ctrlImm[3]` = 1, the request never sets it.
- R9: `outValid` equals `inValid` of the previous clock. `resVec` updates only on accepted requests and holds otherwise. Reset clears `outValid`, `resVec` and `inexFlag`.
- R10: The difference is rounded to half precision in the active mode, according to the sign of the difference. Subnormal inputs and results are exact, with no flush to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe, samples all operands |
| srcVec | input | 16*LANES | Source half-precision lanes |
| bcastEn | input | 1 | Replicate lane 0 of the source to all lanes |
| ctrlImm | input | 8 | [7:4] kept fraction digits, [3] inexact silence, [2] mode source, [1:0] mode |
| dfltMode | input | 2 | External default rounding mode |
| wrMask | input | LANES | Per-lane write enable |
| zeroMode | input | 1 | 1 = zero disabled lanes, 0 = merge |
| oldDst | input | 16*LANES | Previous destination, for merging |
| outValid | output | 1 | Result valid, one clock after the request |
| resVec | output | 16*LANES | Remainder lanes |
| inexFlag | output | 1 | Sticky inexact flag |

## Verification
The bench targets four kinds of corner case.

- **Ties under nearest-even** (1.5 and 2.5 at M = 0). A design that breaks ties the wrong way returns ±0.5 with the wrong sign.
- **Directed modes on tiny inputs.** Rounding up leaves a difference close to −2^−M, which must be rounded again in the chosen mode. A design that skips that second rounding, or drops subnormal bits, gives wrong low bits.
- **Exact inputs under each mode.** A design that mishandles these produces a +0 where −0 is required.
- **Masking, broadcast and the flag.** Disabled lanes and zeroing are swept with random masks. A design that lets a disabled lane, or a silenced request, set the flag is caught when the flag rises too early. A design that clears the flag between requests fails the sticky checks.

// File: rtl/fprd_pkg.sv
package fprd_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic [3:0] fracBits;
    rmode_e     mode;
    logic       quiet;
    logic       bcast;
    logic       zeroFill;
  } ctl_s;

endpackage

// File: rtl/fprd_ctrl.sv
module fprd_ctrl
  import fprd_pkg::*;
(
  input  logic       inValid,
  input  logic [7:0] ctrlImm,
  input  logic [1:0] dfltMode,
  input  logic       bcastEn,
  input  logic       zeroMode,
  output ctl_s       ctl
);
  localparam int FRAC_LSB = 4;

  always_comb begin
    ctl.load     = inValid;
    ctl.fracBits = ctrlImm[FRAC_LSB +: 4];
    ctl.mode     = ctrlImm[2] ? rmode_e'(dfltMode) : rmode_e'(ctrlImm[1:0]);
    ctl.quiet    = ctrlImm[3];
    ctl.bcast    = bcastEn;
    ctl.zeroFill = zeroMode;
  end
endmodule

// File: rtl/fprd_lane.sv
module fprd_lane
  import fprd_pkg::*;
(
  input  logic [15:0] src,
  input  logic [3:0]  fracBits,
  input  rmode_e      mode,
  output logic [15:0] res,
  output logic        inexact
);
  logic              sgn, resSgn, roundUp, inc;
  logic [4:0]        expF, expEff, shU, lead, drop;
  logic [9:0]        frc;
  logic [24:0]       sig, maskW, rem, quo, half, dMag, lowBits, halfR;
  logic signed [6:0] shAmt, bExp;
  logic [10:0]       kept;
  logic [11:0]       mRnd;

  always_comb begin
    sgn     = src[15];
    expF    = src[14:10];
    frc     = src[9:0];
    expEff  = (expF == 5'd0) ? 5'd1 : expF;
    sig     = {14'd0, (expF != 5'd0), frc};
    // count of significand bits that lie below 2^-M
    shAmt   = 7'sd25 - $signed({3'b0, fracBits}) - $signed({2'b0, expEff});
    res     = 16'd0;
    inexact = 1'b0;
    shU     = 5'd0;
    maskW   = 25'd0;
    rem     = 25'd0;
    quo     = 25'd0;
    half    = 25'd0;
    dMag    = 25'd0;
    roundUp = 1'b0;
    resSgn  = sgn;
    lead    = 5'd0;
    bExp    = 7'sd0;
    drop    = 5'd0;
    kept    = 11'd0;
    lowBits = 25'd0;
    halfR   = 25'd0;
    inc     = 1'b0;
    mRnd    = 12'd0;
    if (expF == 5'h1f) begin
      res = (frc != 10'd0) ? {sgn, 5'h1f, 1'b1, frc[8:0]} : {sgn, 15'd0};
    end else if (shAmt <= 7'sd0) begin
      res = {(mode == RM_DOWN), 15'd0};
    end else begin
      shU   = shAmt[4:0];
      maskW = (25'd1 << shU) - 25'd1;
      rem   = sig & maskW;
      quo   = sig >> shU;
      half  = 25'd1 << (shU - 5'd1);
      if (rem == 25'd0) begin
        res = {(mode == RM_DOWN), 15'd0};
      end else begin
        inexact = 1'b1;
        unique case (mode)
          RM_NEAR: roundUp = (rem > half) || ((rem == half) && quo[0]);
          RM_DOWN: roundUp = sgn;
          RM_UP:   roundUp = !sgn;
          default: roundUp = 1'b0;
        endcase
        dMag   = roundUp ? ((25'd1 << shU) - rem) : rem;
        resSgn = sgn ^ roundUp;
        for (int i = 0; i < 25; i++) begin
          if (dMag[i]) lead = 5'(i);
        end
        bExp = $signed({2'b0, lead}) + $signed({2'b0, expEff}) - 7'sd10;
        if (bExp <= 7'sd0) begin
          res = {resSgn, 5'd0, 10'(dMag << (expEff - 5'd1))};
        end else if (lead <= 5'd10) begin
          res = {resSgn, bExp[4:0], 10'(dMag << (5'd10 - lead))};
        end else begin
          drop    = lead - 5'd10;
          kept    = 11'(dMag >> drop);
          lowBits = dMag & ((25'd1 << drop) - 25'd1);
          halfR   = 25'd1 << (drop - 5'd1);
          unique case (mode)
            RM_NEAR: inc = (lowBits > halfR) || ((lowBits == halfR) && kept[0]);
            RM_DOWN: inc = resSgn && (lowBits != 25'd0);
            RM_UP:   inc = !resSgn && (lowBits != 25'd0);
            default: inc = 1'b0;
          endcase
          mRnd = {1'b0, kept} + {11'd0, inc};
          if (mRnd[11]) res = {resSgn, bExp[4:0] + 5'd1, 10'd0};
          else          res = {resSgn, bExp[4:0], mRnd[9:0]};
        end
      end
    end
  end
endmodule

// File: rtl/fprd_datapath.sv
module fprd_datapath
  import fprd_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_s               ctl,
  input  logic [16*LANES-1:0] srcVec,
  input  logic [LANES-1:0]   wrMask,
  input  logic [16*LANES-1:0] oldDst,
  output logic               outValid,
  output logic [16*LANES-1:0] resVec,
  output logic               inexFlag
);
  localparam int VW = 16 * LANES;

  logic [VW-1:0]    nextVec;
  logic [LANES-1:0] actInx;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [15:0] laneSrc, laneRes;
    logic        laneInx;
    assign laneSrc = ctl.bcast ? srcVec[15:0] : srcVec[16*g +: 16];
    fprd_lane uLane (
      .src     (laneSrc),
      .fracBits(ctl.fracBits),
      .mode    (ctl.mode),
      .res     (laneRes),
      .inexact (laneInx)
    );
    assign nextVec[16*g +: 16] = wrMask[g] ? laneRes
                               : (ctl.zeroFill ? 16'd0 : oldDst[16*g +: 16]);
    assign actInx[g] = wrMask[g] & laneInx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      resVec   <= '0;
      inexFlag <= 1'b0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) resVec <= nextVec;
      if (ctl.load && !ctl.quiet && (|actInx)) inexFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/fprd_reduce_unit.sv
module fprd_reduce_unit
  import fprd_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [16*LANES-1:0] srcVec,
  input  logic               bcastEn,
  input  logic [7:0]         ctrlImm,
  input  logic [1:0]         dfltMode,
  input  logic [LANES-1:0]   wrMask,
  input  logic               zeroMode,
  input  logic [16*LANES-1:0] oldDst,
  output logic               outValid,
  output logic [16*LANES-1:0] resVec,
  output logic               inexFlag
);
  ctl_s ctl;

  fprd_ctrl uCtrl (
    .inValid (inValid),
    .ctrlImm (ctrlImm),
    .dfltMode(dfltMode),
    .bcastEn (bcastEn),
    .zeroMode(zeroMode),
    .ctl     (ctl)
  );

  fprd_datapath #(.LANES(LANES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .srcVec  (srcVec),
    .wrMask  (wrMask),
    .oldDst  (oldDst),
    .outValid(outValid),
    .resVec  (resVec),
    .inexFlag(inexFlag)
  );
endmodule

// File: rtl/fprd_reduce_chk.sv
module fprd_reduce_chk #(
  parameter int LANES = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [7:0]         ctrlImm,
  input logic [LANES-1:0]   wrMask,
  input logic               zeroMode,
  input logic [16*LANES-1:0] oldDst,
  input logic               outValid,
  input logic [16*LANES-1:0] resVec,
  input logic               inexFlag
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(resVec)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    inexFlag |=> inexFlag); // R8
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!inexFlag && (!inValid || ctrlImm[3] || (wrMask == '0))) |=> !inexFlag); // R8
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && zeroMode && (wrMask == '0)) |=> (resVec == '0)); // R6
  AST_MASK_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !zeroMode && (wrMask == '0)) |=> (resVec == $past(oldDst))); // R6
endmodule

bind fprd_reduce_unit fprd_reduce_chk #(.LANES(LANES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .ctrlImm (ctrlImm),
  .wrMask  (wrMask),
  .zeroMode(zeroMode),
  .oldDst  (oldDst),
  .outValid(outValid),
  .resVec  (resVec),
  .inexFlag(inexFlag)
);

// File: tb/sim_fprd_reduce_unit.sv
`timescale 1ns/1ps
module sim_fprd_reduce_unit;
  localparam int LANES = 16;
  localparam int VW    = 16 * LANES;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             bcastEn = 1'b0;
  logic             zeroMode = 1'b0;
  logic [VW-1:0]    srcVec = '0;
  logic [VW-1:0]    oldDst = '0;
  logic [7:0]       ctrlImm = '0;
  logic [1:0]       dfltMode = '0;
  logic [LANES-1:0] wrMask = '0;
  logic [VW-1:0]    resVec;
  logic             outValid, inexFlag;

  typedef struct {
    logic [VW-1:0] vec;
    logic          flag;
    string         tag;
  } exp_t;

  exp_t          sbQ[$];
  int            checks = 0;
  int            failures = 0;
  logic          expFlag = 1'b0;
  logic [VW-1:0] lastVec = '0;

  always #4 clk = ~clk;

  fprd_reduce_unit #(.LANES(LANES)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec),
    .bcastEn(bcastEn), .ctrlImm(ctrlImm), .dfltMode(dfltMode),
    .wrMask(wrMask), .zeroMode(zeroMode), .oldDst(oldDst),
    .outValid(outValid), .resVec(resVec), .inexFlag(inexFlag)
  );

  // ---------------- reference model on reals ----------------
  function automatic real p2(int e);
    real r = 1.0;
    if (e >= 0) repeat (e) r = r * 2.0;
    else        repeat (-e) r = r / 2.0;
    return r;
  endfunction

  function automatic real h2r(logic [15:0] h);
    real v;
    if (h[14:10] == 5'd0) v = real'(h[9:0]) * p2(-24);
    else v = real'(1024 + int'(h[9:0])) * p2(int'(h[14:10]) - 25);
    return h[15] ? -v : v;
  endfunction

  function automatic real rint(real v, logic [1:0] md);
    real fl = $floor(v);
    real d;
    case (md)
      2'd0: begin
        d = v - fl;
        if (d > 0.5) return fl + 1.0;
        if (d < 0.5) return fl;
        return ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
      end
      2'd1: return fl;
      2'd2: return $ceil(v);
      default: return (v < 0.0) ? $ceil(v) : fl;
    endcase
  endfunction

  function automatic logic [15:0] encHalf(real v);
    real a = (v < 0.0) ? -v : v;
    int  e = -14;
    int  fr;
    if (a < p2(-14)) begin
      fr = $rtoi(a / p2(-24));
      return {(v < 0.0), 5'd0, fr[9:0]};
    end
    while (a >= p2(e + 1)) e++;
    fr = $rtoi(a / p2(e) * 1024.0) - 1024;
    return {(v < 0.0), 5'(e + 15), fr[9:0]};
  endfunction

  function automatic logic [15:0] r2h(real v, logic [1:0] md);
    real a = (v < 0.0) ? -v : v;
    real q;
    int  e = -14;
    if (a < p2(-14)) q = p2(-24);
    else begin
      while (a >= p2(e + 1)) e++;
      q = p2(e - 10);
    end
    return encHalf(rint(v / q, md) * q);
  endfunction

  task automatic refLane(input logic [15:0] h, input logic [1:0] md, input logic [3:0] m,
                         output logic [15:0] r, output logic inx);
    real x, rv, d;
    inx = 1'b0;
    if (h[14:10] == 5'h1f) begin
      r = (h[9:0] != 10'd0) ? {h[15:10], 1'b1, h[8:0]} : {h[15], 15'd0};
    end else begin
      x   = h2r(h);
      rv  = rint(x * p2(int'(m)), md) * p2(-int'(m));
      inx = (rv != x);
      d   = x - rv;
      r   = (d == 0.0) ? {(md == 2'd1), 15'd0} : r2h(d, md);
    end
  endtask

  function automatic logic [15:0] randHalf();
    logic [15:0] h;
    h = 16'($urandom);
    if ($urandom_range(3, 0) != 0) h[14:10] = 5'($urandom_range(25, 0));
    return h;
  endfunction

  function automatic logic [VW-1:0] randVec();
    logic [VW-1:0] v;
    for (int l = 0; l < LANES; l++) v[16*l +: 16] = randHalf();
    return v;
  endfunction

  // ---------------- check and driver ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic apply(input logic [VW-1:0] src, input logic [7:0] imm, input logic [1:0] dm,
                       input logic [LANES-1:0] msk, input logic zm, input logic bc,
                       input logic [VW-1:0] old, input string tag);
    exp_t        e;
    logic [15:0] a, r;
    logic        inx;
    logic [1:0]  md;
    srcVec = src; ctrlImm = imm; dfltMode = dm; wrMask = msk;
    zeroMode = zm; bcastEn = bc; oldDst = old; inValid = 1'b1;
    md = imm[2] ? dm : imm[1:0];
    for (int l = 0; l < LANES; l++) begin
      a = bc ? src[15:0] : src[16*l +: 16];
      refLane(a, md, imm[7:4], r, inx);
      e.vec[16*l +: 16] = msk[l] ? r : (zm ? 16'd0 : old[16*l +: 16]);
      if (msk[l] && inx && !imm[3]) expFlag = 1'b1;
    end
    e.flag = expFlag;
    e.tag  = tag;
    sbQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    idle(2);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(outValid == 1'b0, "R9", "reset outValid", 32'(outValid), 32'd0);
    chk(resVec == '0, "R9", "reset resVec nonzero", 32'(|resVec), 32'd0);
    chk(inexFlag == 1'b0, "R9", "reset inexFlag", 32'(inexFlag), 32'd0);
    expFlag = 1'b0;
    lastVec = '0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishAll();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  endtask

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    exp_t e;
    if (rstN) begin
      if (outValid) begin
        if (sbQ.size() == 0) begin
          chk(1'b0, "R9", "result without request", 32'd1, 32'd0);
        end else begin
          e = sbQ.pop_front();
          for (int l = 0; l < LANES; l++)
            chk(resVec[16*l +: 16] == e.vec[16*l +: 16], e.tag, $sformatf("lane %0d", l),
                32'(resVec[16*l +: 16]), 32'(e.vec[16*l +: 16]));
          chk(inexFlag == e.flag, "R8", {"inexFlag after ", e.tag},
              32'(inexFlag), 32'(e.flag));
          lastVec = resVec;
        end
      end else begin
        chk(resVec == lastVec, "R9", "hold while idle", 32'(resVec[15:0]), 32'(lastVec[15:0]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishAll();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [VW-1:0] v;
    int mlist[4] = '{0, 1, 5, 15};
    doReset();

    // R1 R4 R5 directed lanes, nearest-even, M=0
    v = randVec();
    v[15:0]    = 16'h3E00;  // 1.5 -> -0.5
    v[31:16]   = 16'h4100;  // 2.5 -> +0.5
    v[47:32]   = 16'h7C00;  // +inf
    v[63:48]   = 16'hFC00;  // -inf
    v[79:64]   = 16'h7C01;  // NaN
    v[95:80]   = 16'h3C00;  // 1.0 exact
    v[111:96]  = 16'h0001;  // min subnormal
    v[127:112] = 16'h8000;  // -0
    apply(v, 8'h00, 2'd0, '1, 1'b0, 1'b0, '0, "R1 R4 R5 directed");
    v[95:80] = 16'h4000;
    apply(v, 8'h01, 2'd0, '1, 1'b0, 1'b0, '0, "R4 exact under mode 1");
    idle(2);

    // R2 R10 mode and M sweep
    for (int md = 0; md < 4; md++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 3; n++)
          apply(randVec(), {4'(mlist[k]), 2'b00, 2'(md)}, 2'd0, '1, 1'b0, 1'b0, '0,
                "R2 R10 sweep");
    idle(3);

    // R3 external mode with conflicting immediate mode bits
    for (int md = 0; md < 4; md++)
      apply(randVec(), {4'(md * 3), 2'b01, 2'(3 - md)}, 2'(md), '1, 1'b0, 1'b0, '0,
            "R3 default mode");

    // R6 merge and zeroing with random masks
    for (int n = 0; n < 6; n++)
      apply(randVec(), 8'h10, 2'd0, LANES'($urandom), 1'(n % 2), 1'b0, randVec(), "R6 masking");
    apply(randVec(), 8'h00, 2'd0, '0, 1'b0, 1'b0, randVec(), "R6 all merge");
    apply(randVec(), 8'h00, 2'd0, '0, 1'b1, 1'b0, randVec(), "R6 all zero");
    idle(2);

    // R7 broadcast
    for (int n = 0; n < 3; n++)
      apply(randVec(), {4'(n), 4'(n)}, 2'd0, '1, 1'b0, 1'b1, '0, "R7 broadcast");

    // R8 flag behaviour from a clean state
    doReset();
    v = {LANES{16'h4000}};
    apply(v, 8'h00, 2'd0, '1, 1'b0, 1'b0, '0, "R8 exact keeps flag low");
    apply({LANES{16'h3E00}}, 8'h08, 2'd0, '1, 1'b0, 1'b0, '0, "R8 silenced");
    v[15:0] = 16'h3E00;
    apply(v, 8'h00, 2'd0, {{(LANES-1){1'b1}}, 1'b0}, 1'b0, 1'b0, '0, "R8 disabled lane");
    apply(v, 8'h00, 2'd0, '1, 1'b0, 1'b0, '0, "R8 sets flag");
    apply({LANES{16'h4000}}, 8'h00, 2'd0, '1, 1'b0, 1'b0, '0, "R8 sticky");
    idle(3);
    chk(sbQ.size() == 0, "R9", "queue drained", 32'(sbQ.size()), 32'd0);
    finishAll();
  end
endmodule